// File: doc/BRIEF.md
# Three-Mode Power-Down Clock Controller

This block decides, cycle by cycle, whether the processor core clock, the peripheral clock and the PLL are enabled. When the core issues an idle strobe, three power-down control bits are decoded into one of three sleep depths. Each depth gates its own set of clocks, waits for its own exit event, and holds the core clock off for its own number of cycles after that event. When the core clock returns, a single-cycle resume pulse marks the first running cycle. If the sleep depth threw away the instruction pipeline, a flush indication comes with that pulse.

All logic runs from an always-on reference clock, which also times the wake-up latency. The peripheral clock enable can run at the full reference rate or at half of it. The clock generators and the core that consume these enables sit outside the block.

Top module: `pwrdn_clk_ctrl`

## Requirements
- R1: After reset, coreClkEn, periClkEn and pllEn are 1, and resumePulse and pipeFlush are 0.
- R2: An idle strobe sampled while running picks the sleep depth by priority. pdwnBit=1 selects all-stop. Otherwise stopAllBit=1 selects core+peripheral. Otherwise stopCkBit=1 selects core-only. coreClkEn is 0 from the cycle after the edge that samples the strobe.
- R3: In core-only sleep, periClkEn keeps running and pllEn stays 1. Only irqIn wakes the block, and wakeIn is ignored. coreClkEn returns CORE_WAKE_CYC (default 2) cycles after the edge that samples irqIn.
- R4: In core+peripheral sleep, periClkEn is 0 and pllEn stays 1. Only wakeIn wakes the block, and irqIn is ignored. With full-rate peripheral clock, coreClkEn returns PERI_WAKE_CYC (default 5) cycles after the edge that samples wakeIn.
- R5: In all-stop sleep, coreClkEn, periClkEn and pllEn are all 0, and wakeIn is ignored. pllEn returns to 1 in the cycle after the edge that samples irqIn.
- R6: In all-stop sleep, coreClkEn returns PLL_WAKE_CYC (default 500) cycles after the edge that samples irqIn.
- R7: With halfRateSel=1, periClkEn is high on alternate cycles while the peripheral clock runs, starting high. The phase restarts each time the peripheral clock is gated.
- R8: In core+peripheral sleep, if halfRateSel=1 when wakeIn is sampled, the latency is PERI_WAKE_CYC+1 (default 6).
- R9: resumePulse is high for exactly one cycle, which is the first cycle of coreClkEn high after a sleep.
- R10: pipeFlush is high together with resumePulse after core+peripheral and all-stop sleep. It stays 0 after core-only sleep.
- R11: An idle strobe with all three control bits at 0 causes no gating.
- R12: Idle strobes during sleep or wake-up are ignored. irqIn and wakeIn are ignored while running or while the wake-up count is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rstN | input | 1 | Active-low reset |
| pdwnBit | input | 1 | Request to stop the PLL as well (deepest sleep) |
| stopAllBit | input | 1 | Request to stop the core and peripheral clocks |
| stopCkBit | input | 1 | Request to stop the core clock only |
| halfRateSel | input | 1 | Peripheral clock at half the reference rate |
| idleReq | input | 1 | Idle strobe from the core |
| irqIn | input | 1 | Interrupt; exit event for core-only and all-stop sleep |
| wakeIn | input | 1 | Wake-up event; exit event for core+peripheral sleep |
| coreClkEn | output | 1 | Core clock enable |
| periClkEn | output | 1 | Peripheral clock enable |
| pllEn | output | 1 | PLL enable |
| pipeFlush | output | 1 | Pipeline must be refilled on resume |
| resumePulse | output | 1 | First cycle of execution after sleep |

## Verification
The bench builds the block with its default latencies of 2, 5 and 500 cycles. This keeps every wake-up window at its real length, including the full PLL restabilisation count and the extra cycle added at half peripheral rate. A behavioural model tracks each sleep depth with plain integers and compares all five enables on every cycle. Directed scenarios measure each latency from the exit event to the resume pulse, and they drive the wrong exit event and repeated idle strobes into every depth.

// File: rtl/pwrdn_clk_pkg.sv
package pwrdn_clk_pkg;

  typedef enum logic [1:0] {
    MODE_NONE     = 2'd0,
    MODE_CORE     = 2'd1,
    MODE_COREPERI = 2'd2,
    MODE_ALL      = 2'd3
  } pdMode_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAKE  = 2'd2
  } pdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadCnt;   // exit event accepted: start latency count
    pdMode_e latMode;   // depth whose latency applies
    logic    wakeDone;  // last wake cycle, core resumes next cycle
    logic    flushReq;  // pipeline was lost in this depth
    logic    periRun;   // peripheral clock allowed this cycle
  } pdStrobe_t;

endpackage

// File: rtl/pwrdn_clk_ctrl_fsm.sv
module pwrdn_clk_ctrl_fsm
  import pwrdn_clk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pdwnBit,
  input  logic      stopAllBit,
  input  logic      stopCkBit,
  input  logic      idleReq,
  input  logic      irqIn,
  input  logic      wakeIn,
  input  logic      cntZero,
  output pdStrobe_t strobe,
  output logic      coreClkEn,
  output logic      pllEn
);

  pdState_e state, stateNext;
  pdMode_e  modeReg, decodedMode;
  logic     exitHit;

  // priority decode of the control bits at idle time
  always_comb begin
    if (pdwnBit)         decodedMode = MODE_ALL;
    else if (stopAllBit) decodedMode = MODE_COREPERI;
    else if (stopCkBit)  decodedMode = MODE_CORE;
    else                 decodedMode = MODE_NONE;
  end

  // each depth listens to its own exit event
  always_comb begin
    if (modeReg == MODE_COREPERI) exitHit = wakeIn;
    else                          exitHit = irqIn;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_RUN:   if (idleReq && decodedMode != MODE_NONE) stateNext = ST_SLEEP;
      ST_SLEEP: if (exitHit)                             stateNext = ST_WAKE;
      ST_WAKE:  if (cntZero)                             stateNext = ST_RUN;
      default:                                           stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      modeReg <= MODE_NONE;
    end else begin
      state <= stateNext;
      if (state == ST_RUN && idleReq && decodedMode != MODE_NONE)
        modeReg <= decodedMode;
    end
  end

  always_comb begin
    strobe.loadCnt  = (state == ST_SLEEP) && exitHit;
    strobe.latMode  = modeReg;
    strobe.wakeDone = (state == ST_WAKE) && cntZero;
    strobe.flushReq = (state == ST_WAKE) && cntZero && (modeReg != MODE_CORE);
    strobe.periRun  = (state == ST_RUN) || (modeReg == MODE_CORE);
  end

  assign coreClkEn = (state == ST_RUN);
  assign pllEn     = !((state == ST_SLEEP) && (modeReg == MODE_ALL));

endmodule

// File: rtl/pwrdn_clk_datapath.sv
module pwrdn_clk_datapath
  import pwrdn_clk_pkg::*;
#(
  parameter int CORE_WAKE_CYC = 2,
  parameter int PERI_WAKE_CYC = 5,
  parameter int PLL_WAKE_CYC  = 500
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      halfRateSel,
  input  pdStrobe_t strobe,
  output logic      cntZero,
  output logic      periClkEn,
  output logic      resumePulse,
  output logic      pipeFlush
);

  localparam int MAX_A   = (CORE_WAKE_CYC > PERI_WAKE_CYC + 1) ? CORE_WAKE_CYC : PERI_WAKE_CYC + 1;
  localparam int MAX_LAT = (MAX_A > PLL_WAKE_CYC) ? MAX_A : PLL_WAKE_CYC;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic [CNT_W-1:0] wakeCnt, loadVal;
  logic             periPhase;

  // latency per depth, minus the cycle spent loading
  always_comb begin
    case (strobe.latMode)
      MODE_CORE:     loadVal = CNT_W'(CORE_WAKE_CYC - 1);
      MODE_COREPERI: loadVal = CNT_W'(PERI_WAKE_CYC - 1) + CNT_W'(halfRateSel);
      MODE_ALL:      loadVal = CNT_W'(PLL_WAKE_CYC - 1);
      default:       loadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                wakeCnt <= '0;
    else if (strobe.loadCnt)  wakeCnt <= loadVal;
    else if (wakeCnt != '0)   wakeCnt <= wakeCnt - 1'b1;
  end

  assign cntZero = (wakeCnt == '0);

  // half-rate divider; phase restarts whenever the peripheral clock stops
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              periPhase <= 1'b0;
    else if (strobe.periRun && halfRateSel) periPhase <= ~periPhase;
    else                                    periPhase <= 1'b0;
  end

  assign periClkEn = strobe.periRun && (!halfRateSel || !periPhase);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resumePulse <= 1'b0;
      pipeFlush   <= 1'b0;
    end else begin
      resumePulse <= strobe.wakeDone;
      pipeFlush   <= strobe.flushReq;
    end
  end

endmodule

// File: rtl/pwrdn_clk_ctrl.sv
module pwrdn_clk_ctrl
  import pwrdn_clk_pkg::*;
#(
  parameter int CORE_WAKE_CYC = 2,
  parameter int PERI_WAKE_CYC = 5,
  parameter int PLL_WAKE_CYC  = 500
) (
  input  logic clk,
  input  logic rstN,
  input  logic pdwnBit,
  input  logic stopAllBit,
  input  logic stopCkBit,
  input  logic halfRateSel,
  input  logic idleReq,
  input  logic irqIn,
  input  logic wakeIn,
  output logic coreClkEn,
  output logic periClkEn,
  output logic pllEn,
  output logic pipeFlush,
  output logic resumePulse
);

  pdStrobe_t strobe;
  logic      cntZero;

  pwrdn_clk_ctrl_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .pdwnBit    (pdwnBit),
    .stopAllBit (stopAllBit),
    .stopCkBit  (stopCkBit),
    .idleReq    (idleReq),
    .irqIn      (irqIn),
    .wakeIn     (wakeIn),
    .cntZero    (cntZero),
    .strobe     (strobe),
    .coreClkEn  (coreClkEn),
    .pllEn      (pllEn)
  );

  pwrdn_clk_datapath #(
    .CORE_WAKE_CYC (CORE_WAKE_CYC),
    .PERI_WAKE_CYC (PERI_WAKE_CYC),
    .PLL_WAKE_CYC  (PLL_WAKE_CYC)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .halfRateSel (halfRateSel),
    .strobe      (strobe),
    .cntZero     (cntZero),
    .periClkEn   (periClkEn),
    .resumePulse (resumePulse),
    .pipeFlush   (pipeFlush)
  );

endmodule

// File: rtl/pwrdn_clk_ctrl_chk.sv
module pwrdn_clk_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic pdwnBit,
  input logic stopAllBit,
  input logic stopCkBit,
  input logic idleReq,
  input logic coreClkEn,
  input logic periClkEn,
  input logic pllEn,
  input logic pipeFlush,
  input logic resumePulse
);

  assert_core_off_after_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreClkEn) |-> $past(idleReq));

  assert_pll_off_gates_all_R5: assert property (@(posedge clk) disable iff (!rstN)
    !pllEn |-> (!coreClkEn && !periClkEn));

  assert_resume_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    resumePulse |=> !resumePulse);

  assert_resume_on_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreClkEn) |-> resumePulse);

  assert_flush_with_resume_R10: assert property (@(posedge clk) disable iff (!rstN)
    pipeFlush |-> resumePulse);

  assert_no_bits_no_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    (idleReq && coreClkEn && !pdwnBit && !stopAllBit && !stopCkBit) |=> coreClkEn);

endmodule

bind pwrdn_clk_ctrl pwrdn_clk_ctrl_chk u_chk (.*);

// File: tb/pwrdn_clk_ctrl_bench.sv
`timescale 1ns/1ps
module pwrdn_clk_ctrl_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pdwnBit = 0, stopAllBit = 0, stopCkBit = 0, halfRateSel = 0;
  logic idleReq = 0, irqIn = 0, wakeIn = 0;
  logic coreClkEn, periClkEn, pllEn, pipeFlush, resumePulse;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  bit cmpOn = 0;

  always #2 clk = ~clk;

  pwrdn_clk_ctrl u_pwrdn_clk_ctrl (
    .clk(clk), .rstN(rstN), .pdwnBit(pdwnBit), .stopAllBit(stopAllBit),
    .stopCkBit(stopCkBit), .halfRateSel(halfRateSel), .idleReq(idleReq),
    .irqIn(irqIn), .wakeIn(wakeIn), .coreClkEn(coreClkEn), .periClkEn(periClkEn),
    .pllEn(pllEn), .pipeFlush(pipeFlush), .resumePulse(resumePulse));

  // behavioural model: 0 run, 1 asleep, 2 counting; depth 1 core, 2 core+peri, 3 all
  int mState = 0, mDepth = 0, mLeft = 0, mPhase = 0;
  int mResume = 0, mFlush = 0;

  always @(posedge clk) begin
    int runPeri;
    runPeri = (mState == 0 || mDepth == 1) ? 1 : 0;
    if (!rstN) begin
      mState = 0; mDepth = 0; mLeft = 0; mPhase = 0; mResume = 0; mFlush = 0;
    end else begin
      mResume = 0; mFlush = 0;
      if (mState == 0) begin
        if (idleReq && (pdwnBit || stopAllBit || stopCkBit)) begin
          mDepth = pdwnBit ? 3 : (stopAllBit ? 2 : 1);
          mState = 1;
        end
      end else if (mState == 1) begin
        if ((mDepth == 2 && wakeIn) || (mDepth != 2 && irqIn)) begin
          mState = 2;
          mLeft = (mDepth == 1) ? 2 : (mDepth == 2 ? 5 + (halfRateSel ? 1 : 0) : 500);
        end
      end else begin
        mLeft--;
        if (mLeft == 0) begin
          mState = 0; mResume = 1; mFlush = (mDepth != 1) ? 1 : 0;
        end
      end
      mPhase = (runPeri == 1 && halfRateSel) ? 1 - mPhase : 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (cmpOn && !done) begin
      int eCore, ePeri, ePll;
      eCore = (mState == 0) ? 1 : 0;
      ePeri = ((mState == 0 || mDepth == 1) && (!halfRateSel || mPhase == 0)) ? 1 : 0;
      ePll  = (mState == 1 && mDepth == 3) ? 0 : 1;
      check(int'(coreClkEn) == eCore, "R2 coreClkEn", int'(coreClkEn), eCore);
      check(int'(periClkEn) == ePeri, "R7 periClkEn", int'(periClkEn), ePeri);
      check(int'(pllEn) == ePll, "R5 pllEn", int'(pllEn), ePll);
      check(int'(resumePulse) == mResume, "R9 resumePulse", int'(resumePulse), mResume);
      check(int'(pipeFlush) == mFlush, "R10 pipeFlush", int'(pipeFlush), mFlush);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic idlePulse();
    idleReq = 1; step(1); idleReq = 0;
  endtask

  // fires an exit event and measures cycles from its sampling edge to resume
  task automatic wakeMeasure(input bit useWake, input int expLat, input int expFlush, input string req);
    int n;
    if (useWake) wakeIn = 1; else irqIn = 1;
    @(negedge clk);
    n = 1;
    check(pllEn == 1'b1, "R5 pll back after exit event", int'(pllEn), 1);
    #1 wakeIn = 0; irqIn = 0;
    while (!coreClkEn && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(n - 1 == expLat, req, n - 1, expLat);
    check(resumePulse == 1'b1, "R9 pulse on first run cycle", int'(resumePulse), 1);
    check(int'(pipeFlush) == expFlush, "R10 flush on resume", int'(pipeFlush), expFlush);
    @(negedge clk);
    check(resumePulse == 1'b0, "R9 pulse lasts one cycle", int'(resumePulse), 0);
    #1;
  endtask

  initial begin
    step(3);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(coreClkEn && periClkEn && pllEn, "R1 enables after reset", int'({coreClkEn, periClkEn, pllEn}), 7);
    check(!resumePulse && !pipeFlush, "R1 pulses after reset", int'({resumePulse, pipeFlush}), 0);
    cmpOn = 1;
    #1;

    // R11 idle with no bits
    idlePulse(); step(2);
    check(coreClkEn == 1'b1, "R11 no gating without bits", int'(coreClkEn), 1);

    // R12 events while running
    irqIn = 1; wakeIn = 1; step(1); irqIn = 0; wakeIn = 0; step(2);
    check(coreClkEn && !resumePulse, "R12 events ignored while running", int'(coreClkEn), 1);

    // R3 core-only sleep
    stopCkBit = 1; idlePulse(); stopCkBit = 0; step(1);
    check(!coreClkEn && periClkEn && pllEn, "R3 core-only gating", int'({coreClkEn, periClkEn, pllEn}), 3);
    wakeIn = 1; step(1); wakeIn = 0; step(3);
    check(coreClkEn == 1'b0, "R3 wakeIn ignored in core-only", int'(coreClkEn), 0);
    idlePulse(); step(1);
    check(coreClkEn == 1'b0, "R12 idle ignored while asleep", int'(coreClkEn), 0);
    wakeMeasure(0, 2, 0, "R3 core-only latency");

    // R2 priority and R4 core+peripheral sleep
    stopAllBit = 1; stopCkBit = 1; idlePulse(); stopAllBit = 0; stopCkBit = 0; step(1);
    check(!coreClkEn && !periClkEn && pllEn, "R4 core+peri gating (R2 priority)", int'({coreClkEn, periClkEn, pllEn}), 1);
    irqIn = 1; step(1); irqIn = 0; step(3);
    check(coreClkEn == 1'b0, "R4 irq ignored in core+peri", int'(coreClkEn), 0);
    wakeMeasure(1, 5, 1, "R4 core+peri latency");

    // R7 and R8 half-rate
    halfRateSel = 1; step(6);
    stopAllBit = 1; idlePulse(); stopAllBit = 0; step(4);
    wakeMeasure(1, 6, 1, "R8 half-rate core+peri latency");
    step(3);

    // R7 peripheral keeps toggling in core-only sleep at half rate
    stopCkBit = 1; idlePulse(); stopCkBit = 0; step(7);
    wakeMeasure(0, 2, 0, "R3 core-only latency at half rate");
    halfRateSel = 0; step(2);

    // R5 R6 all-stop with R2 priority
    pdwnBit = 1; stopAllBit = 1; stopCkBit = 1; idlePulse();
    pdwnBit = 0; stopAllBit = 0; stopCkBit = 0; step(1);
    check(!coreClkEn && !periClkEn && !pllEn, "R5 all-stop gating", int'({coreClkEn, periClkEn, pllEn}), 0);
    wakeIn = 1; step(1); wakeIn = 0; step(3);
    check(pllEn == 1'b0, "R5 wakeIn ignored in all-stop", int'(pllEn), 0);
    wakeMeasure(0, 500, 1, "R6 all-stop latency");

    // R12 events during the wake count
    stopAllBit = 1; idlePulse(); stopAllBit = 0; step(2);
    wakeIn = 1; step(1); wakeIn = 0;
    irqIn = 1; wakeIn = 1; idleReq = 1; step(1); irqIn = 0; wakeIn = 0; idleReq = 0;
    step(4);
    check(coreClkEn == 1'b1, "R12 events ignored during wake count", int'(coreClkEn), 1);
    step(4);

    cmpOn = 0;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule